// File: doc/BRIEF.md
# Interrupt Controller Global Timer Bank

This block holds four down-counting timers that an interrupt controller uses to raise periodic requests. Each timer has a reload (base) register and a live count register, both reached through a small register port with a byte address, a write strobe and write data. Reads are combinational on the same address lines. A free-running prescaler divides the input clock by a fixed factor of 4 or 8 and gives one tick strobe. All four timers share that strobe.

The top bit of each base register is a stop flag. Clearing it starts the timer from the written reload value. Setting it halts the timer and zeroes the count. A running timer counts down by one on each tick. On the tick where its count is already zero, it reloads from the base value, inverts a phase bit kept in the top bit of the count register, and pulses its own request line for one clock. Routing, priority and acknowledge of those requests are handled elsewhere.

Top module: `gtmr_bank`

## Requirements
- R1: After reset every count register reads 0x00000000, every base register reads 0x80000000 (stopped), and all request lines are low.
- R2: Address bits [7:6] select the timer. Offset 0x00 within the slot (bits [5:0] = 0x00) is the count register and offset 0x10 is the base register. Reads return the addressed register in the same cycle. Any other offset reads as zero and ignores writes.
- R3: A base write that takes bit 31 from 1 to 0 loads the count with bits [30:0] of the written data and clears the phase bit (count bit 31).
- R4: The tick strobe fires once every PRESCALE clocks, on clock edges PRESCALE, 2·PRESCALE and so on after reset. All timers that are not stopped decrement by one on the same tick.
- R5: When a running timer sees a tick with count 0, it reloads the count from base bits [30:0] and inverts the phase bit.
- R6: Each reload drives that timer's request line high for exactly one clock, right after the tick edge. With base value B, the pulses are (B+1)·PRESCALE clocks apart.
- R7: A base write that takes bit 31 from 0 to 1 clears count bits [30:0] and keeps the phase bit. While stopped, the count stays 0 and no request is raised.
- R8: A base write that leaves bit 31 unchanged only replaces the stored base value. A running count continues undisturbed.
- R9: Writes to a count register have no effect.
- R10: A running timer whose base value is 0 expires on every tick, so it inverts its phase bit and pulses its request once per PRESCALE clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address for read and write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for the register at `addr` |
| irq | output | 4 | One-clock request pulse per timer |

## Verification
Read data is combinational, so a read is sampled a moment after its address is driven, with no clock edge in between. A register write takes effect at the next clock edge. A count changes only on tick edges, and a request line is high for the clock that follows the tick edge on which its timer reloaded. The bench aligns to the edge right after a tick. Every table entry then lasts a whole number of tick periods, so each expected count follows from the number of ticks elapsed. Request pulses are found by sampling at each falling edge after a start write and recording the index of the first pulse and the total number of pulses.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
  localparam int unsigned TMR_COUNT = 4;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned VAL_W     = DATA_W - 1;
  localparam int unsigned IDX_W     = $clog2(TMR_COUNT);

  // Strobes from control to datapath, valid for one clock.
  typedef struct packed {
    logic                 tick;
    logic [TMR_COUNT-1:0] baseWr;
    logic [TMR_COUNT-1:0] startEv;
    logic [TMR_COUNT-1:0] stopEv;
    logic [IDX_W-1:0]     rdIdx;
    logic                 rdCnt;
    logic                 rdBase;
  } tmrCtrl_t;
endpackage

// File: rtl/gtmr_ctrl.sv
module gtmr_ctrl
  import gtmr_pkg::*;
#(
  parameter int unsigned PRESCALE = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wrInhibit,
  input  logic [TMR_COUNT-1:0] inhibit,
  output tmrCtrl_t             ctrl
);
  localparam int unsigned PS_W = $clog2(PRESCALE);

  logic [PS_W-1:0] psCnt;
  logic            tickNow;
  logic [IDX_W-1:0] slotIdx;
  logic            offCnt;
  logic            offBase;

  assign tickNow = (psCnt == PS_W'(PRESCALE - 1));

  always_ff @(posedge clk) begin
    if (!rstN) psCnt <= '0;
    else if (tickNow) psCnt <= '0;
    else psCnt <= psCnt + PS_W'(1);
  end

  assign slotIdx = addr[ADDR_W-1 -: IDX_W];
  assign offCnt  = (addr[5:0] == 6'h00);
  assign offBase = (addr[5:0] == 6'h10);

  always_comb begin
    ctrl.tick   = tickNow;
    ctrl.rdIdx  = slotIdx;
    ctrl.rdCnt  = offCnt;
    ctrl.rdBase = offBase;
  end

  for (genvar i = 0; i < TMR_COUNT; i++) begin : g_dec
    always_comb begin
      ctrl.baseWr[i]  = wrEn && offBase && (slotIdx == IDX_W'(i));
      ctrl.startEv[i] = ctrl.baseWr[i] && inhibit[i] && !wrInhibit;
      ctrl.stopEv[i]  = ctrl.baseWr[i] && !inhibit[i] && wrInhibit;
    end
  end
endmodule

// File: rtl/gtmr_datapath.sv
module gtmr_datapath
  import gtmr_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  tmrCtrl_t                        ctrl,
  input  logic [DATA_W-1:0]               wrData,
  output logic [DATA_W-1:0]               rdData,
  output logic [TMR_COUNT-1:0]            irq,
  output logic [TMR_COUNT-1:0]            inhibit,
  output logic [TMR_COUNT-1:0][VAL_W-1:0] cntVal,
  output logic [TMR_COUNT-1:0]            togBit
);
  logic [TMR_COUNT-1:0][DATA_W-1:0] baseReg;

  for (genvar i = 0; i < TMR_COUNT; i++) begin : g_tmr
    assign inhibit[i] = baseReg[i][DATA_W-1];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseReg[i] <= {1'b1, {VAL_W{1'b0}}};
        cntVal[i]  <= '0;
        togBit[i]  <= 1'b0;
        irq[i]     <= 1'b0;
      end else begin
        irq[i] <= 1'b0;
        if (ctrl.baseWr[i]) baseReg[i] <= wrData;
        if (ctrl.startEv[i]) begin
          cntVal[i] <= wrData[VAL_W-1:0];
          togBit[i] <= 1'b0;
        end else if (ctrl.stopEv[i]) begin
          cntVal[i] <= '0;
        end else if (ctrl.tick && !inhibit[i]) begin
          if (cntVal[i] == '0) begin
            cntVal[i] <= baseReg[i][VAL_W-1:0];
            togBit[i] <= ~togBit[i];
            irq[i]    <= 1'b1;
          end else begin
            cntVal[i] <= cntVal[i] - VAL_W'(1);
          end
        end
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (ctrl.rdCnt)       rdData = {togBit[ctrl.rdIdx], cntVal[ctrl.rdIdx]};
    else if (ctrl.rdBase) rdData = baseReg[ctrl.rdIdx];
  end
endmodule

// File: rtl/gtmr_bank.sv
module gtmr_bank
  import gtmr_pkg::*;
#(
  parameter int unsigned PRESCALE = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic [TMR_COUNT-1:0] irq
);
  tmrCtrl_t                        ctrl;
  logic [TMR_COUNT-1:0]            inhibit;
  logic [TMR_COUNT-1:0][VAL_W-1:0] cntVal;
  logic [TMR_COUNT-1:0]            togBit;

  gtmr_ctrl #(.PRESCALE(PRESCALE)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .addr      (addr),
    .wrInhibit (wrData[DATA_W-1]),
    .inhibit   (inhibit),
    .ctrl      (ctrl)
  );

  gtmr_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .wrData  (wrData),
    .rdData  (rdData),
    .irq     (irq),
    .inhibit (inhibit),
    .cntVal  (cntVal),
    .togBit  (togBit)
  );
endmodule

// File: rtl/gtmr_bank_chk.sv
module gtmr_bank_chk
  import gtmr_pkg::*;
(
  input logic                            clk,
  input logic                            rstN,
  input logic                            wrEn,
  input logic [ADDR_W-1:0]               addr,
  input logic [DATA_W-1:0]               wrData,
  input logic [TMR_COUNT-1:0]            irq,
  input logic                            tick,
  input logic [TMR_COUNT-1:0]            inhibit,
  input logic [TMR_COUNT-1:0][VAL_W-1:0] cntVal
);
  // R4: ticks are never on adjacent clocks
  a_r4_tick_gap: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);

  for (genvar i = 0; i < TMR_COUNT; i++) begin : g_chk
    logic startWr;
    assign startWr = wrEn && (addr == {IDX_W'(i), 6'h10}) && !wrData[DATA_W-1];

    // R6: a request is a single-clock pulse
    a_r6_irq_single: assert property (@(posedge clk) disable iff (!rstN)
      irq[i] |=> !irq[i]);

    // R6: a request only follows a tick edge
    a_r6_irq_after_tick: assert property (@(posedge clk) disable iff (!rstN)
      irq[i] |-> $past(tick));

    // R7: a stopped timer holds zero and stays quiet
    a_r7_stopped_idle: assert property (@(posedge clk) disable iff (!rstN)
      (inhibit[i] && !startWr) |=> (cntVal[i] == '0) && !irq[i]);

    // R3: a start write loads the written value
    a_r3_start_loads: assert property (@(posedge clk) disable iff (!rstN)
      (inhibit[i] && startWr) |=> cntVal[i] == $past(wrData[VAL_W-1:0]));
  end
endmodule

bind gtmr_bank gtmr_bank_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .addr    (addr),
  .wrData  (wrData),
  .irq     (irq),
  .tick    (ctrl.tick),
  .inhibit (inhibit),
  .cntVal  (cntVal)
);

// File: tb/gtmr_bank_tb.sv
`timescale 1ns/1ps
module gtmr_bank_tb;
  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [3:0]  irq;

  int checks = 0;
  int failures = 0;
  int edgeCnt = 0;

  gtmr_bank #(.PRESCALE(P)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  always #2 clk = ~clk;
  always @(posedge clk) if (rstN) edgeCnt <= edgeCnt + 1;

  typedef struct packed {
    logic        isWr;
    logic [7:0]  adr;
    logic [31:0] dat;
    logic [3:0]  tks;
    logic [31:0] exp;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 8'h10, 32'h0000_0005, 4'd1, 32'h0,          "R3"},  // start T0 at 5
    '{1'b0, 8'h00, 32'h0,         4'd3, 32'h0000_0004, "R4"},
    '{1'b0, 8'h00, 32'h0,         4'd2, 32'h0000_0001, "R4"},
    '{1'b0, 8'h00, 32'h0,         4'd1, 32'h8000_0005, "R5"},  // reloaded, phase set
    '{1'b1, 8'h00, 32'h0000_0123, 4'd1, 32'h0,          "R9"},  // ignored write
    '{1'b0, 8'h00, 32'h0,         4'd1, 32'h8000_0003, "R9"},
    '{1'b1, 8'h10, 32'h0000_0009, 4'd1, 32'h0,          "R8"},  // base only
    '{1'b0, 8'h10, 32'h0,         4'd1, 32'h0000_0009, "R8"},
    '{1'b0, 8'h00, 32'h0,         4'd1, 32'h8000_0000, "R8"},
    '{1'b0, 8'h00, 32'h0,         4'd1, 32'h0000_0009, "R5"},
    '{1'b1, 8'h10, 32'h8000_0009, 4'd2, 32'h0,          "R7"},  // stop T0
    '{1'b0, 8'h00, 32'h0,         4'd1, 32'h0000_0000, "R7"},
    '{1'b0, 8'h10, 32'h0,         4'd1, 32'h8000_0009, "R2"},
    '{1'b1, 8'h90, 32'h0000_0000, 4'd1, 32'h0,          "R10"}, // T2 base 0
    '{1'b0, 8'h80, 32'h0,         4'd1, 32'h8000_0000, "R10"},
    '{1'b0, 8'h80, 32'h0,         4'd1, 32'h0000_0000, "R10"},
    '{1'b1, 8'h90, 32'h8000_0000, 4'd2, 32'h0,          "R7"},  // stop with phase 1
    '{1'b0, 8'h80, 32'h0,         4'd1, 32'h8000_0000, "R7"},
    '{1'b0, 8'h40, 32'h0,         4'd1, 32'h0000_0000, "R2"},
    '{1'b0, 8'h50, 32'h0,         4'd1, 32'h8000_0000, "R2"}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #1;
    check(tag, rdData, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic alignTick;
    while (edgeCnt % P != 0) @(negedge clk);
  endtask

  task automatic countPulses(input int bit_i, input int cycles, output int first, output int pulses, output int bad);
    first = 0; pulses = 0; bad = 0;
    for (int c = 1; c <= cycles; c++) begin
      if (c > 1) @(negedge clk);
      if (irq[bit_i]) begin
        pulses++;
        if (first == 0) first = c;
      end
      if ((irq & ~(4'b1 << bit_i)) != 4'b0) bad++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int first, pulses, bad;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state, before any edge out of reset
    for (int t = 0; t < 4; t++) begin
      rd(8'(t * 64),        32'h0000_0000, "R1 count");
      rd(8'(t * 64 + 16),   32'h8000_0000, "R1 base");
    end
    check("R1 irq", {28'h0, irq}, 32'h0);
    @(negedge clk);

    // Table walk: each entry spans tks whole tick periods
    alignTick();
    for (int n = 0; n < NV; n++) begin
      if (TBL[n].isWr) begin
        wr(TBL[n].adr, TBL[n].dat);
        repeat (P * int'(TBL[n].tks) - 1) @(negedge clk);
      end else begin
        rd(TBL[n].adr, TBL[n].exp, $sformatf("%s row %0d", TBL[n].tag, n));
        repeat (P * int'(TBL[n].tks)) @(negedge clk);
      end
    end

    // R4: two timers started inside one tick period decrement together
    alignTick();
    wr(8'h10, 32'h0000_0007);
    wr(8'h50, 32'h0000_0007);
    repeat (2) @(negedge clk);
    rd(8'h00, 32'h0000_0006, "R4 shared tick T0");
    rd(8'h40, 32'h0000_0006, "R4 shared tick T1");
    wr(8'h10, 32'h8000_0000);
    wr(8'h50, 32'h8000_0000);

    // R6: base 2 gives pulses every 12 clocks, first after edge 12
    alignTick();
    wrEn = 1'b1; addr = 8'hD0; wrData = 32'h0000_0002;
    @(negedge clk);
    wrEn = 1'b0;
    countPulses(3, 48, first, pulses, bad);
    check("R6 first pulse clock", 32'(first), 32'd12);
    check("R6 pulse count", 32'(pulses), 32'd4);
    check("R6 other lines quiet", 32'(bad), 32'd0);
    wr(8'hD0, 32'h8000_0000);
    @(negedge clk);
    check("R7 stopped irq", {28'h0, irq}, 32'h0);

    // R10: base 0 pulses on every tick
    alignTick();
    wrEn = 1'b1; addr = 8'h90; wrData = 32'h0000_0000;
    @(negedge clk);
    wrEn = 1'b0;
    countPulses(2, 16, first, pulses, bad);
    check("R10 first pulse clock", 32'(first), 32'd4);
    check("R10 pulse count", 32'(pulses), 32'd4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule